// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of W bits each and returns their full 2W-bit signed product. The multiplier operand is recoded on the fly into signed digits in the range -2 to +2. Each digit comes from a window of three multiplier bits. Neighbouring windows share one bit, and the lowest window reads an implied zero below bit 0. A digit selects nothing, the multiplicand, or twice the multiplicand, either added or subtracted. The selected term goes into an accumulator, which then shifts right by two places. Two multiplier bits are consumed per clock, so a product takes W/2 working cycles.

A caller raises `start` for one cycle with both operands while the block is idle. `busy` stays high during the iterations. `done` pulses for one cycle when `product` has been updated, and `product` then holds that value until the next operation completes. The most negative operand value, on either or both inputs, gives the correct result.

Top module: `booth4_mul`

## Requirements
- R1: After an accepted start, `product` equals the signed product of the captured `mcand` and `mplier`, interpreted as W-bit two's complement and returned as 2W-bit two's complement.
- R2: A start is accepted only when `busy` is low. Acceptance captures both operands, and `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle. It rises after the W/2-th rising edge that follows the edge at which the start was accepted, and `busy` is low in that same cycle.
- R4: A `start` raised while `busy` is high is ignored. The running operation finishes with its original operands and its original timing.
- R5: The most negative operand -2^(W-1) is handled on either input. In particular, (-2^(W-1)) x (-2^(W-1)) gives +2^(2W-2), which is 16384 for W = 8.
- R6: `product` changes only in a cycle where `done` is high. Otherwise it keeps the last result.
- R7: While `rst` is high at a rising edge, `busy`, `done` and `product` become zero.
- R8: Each multiplier bit window (b[i+1], b[i], b[i-1]) maps to a digit as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. The digit of the window at bit 2j has weight 4^j. For example, the multiplier 0x5A (90) times 23 gives 2070, and 23 x 6 gives 138.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement, Booth-recoded |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: product just updated |
| product | output | 2W | Signed product, held between results |

## Verification
A start is sampled at one rising edge, and its `done` with the new `product` appears after W/2 further edges, which is four cycles at the default width. The driver records the cycle count at the falling edge where it raises `start`, and pushes the expected product into a queue. The monitor samples `done` and `product` on falling edges only. It checks both the value and that exactly W/2+1 cycles separate the drive from the `done` it sees. Starts raised during `busy` are not queued, so any effect they had would show up as a wrong value, an extra `done` or a shifted latency.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // One recoded Booth digit: zero, or +/- (1 or 2) times the multiplicand
  typedef struct packed {
    logic zero;
    logic neg;
    logic dbl;
  } bdigit_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // Window {upper, middle, lower} -> signed digit
  function automatic bdigit_t decode_window(input logic [2:0] win);
    bdigit_t d;
    d = '{zero: 1'b0, neg: 1'b0, dbl: 1'b0};
    unique case (win)
      3'b000, 3'b111: d.zero = 1'b1;
      3'b001, 3'b010: d     = '{zero: 1'b0, neg: 1'b0, dbl: 1'b0};
      3'b011:         d     = '{zero: 1'b0, neg: 1'b0, dbl: 1'b1};
      3'b100:         d     = '{zero: 1'b0, neg: 1'b1, dbl: 1'b1};
      default:        d     = '{zero: 1'b0, neg: 1'b1, dbl: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
  import booth4_pkg::*;
(
  input  logic [2:0] win,
  output bdigit_t    digit
);

  always_comb digit = decode_window(win);

endmodule

// File: rtl/booth4_addend.sv
// Builds the accumulator term for one digit: sign-extended multiplicand,
// optionally doubled, optionally inverted (negation completes with cin).
module booth4_addend
  import booth4_pkg::*;
#(
  parameter int W = 8,
  localparam int AW = W + 2
) (
  input  logic [W-1:0]  mcand,
  input  bdigit_t       digit,
  output logic [AW-1:0] addend,
  output logic          cin
);

  logic [AW-1:0] one_x;
  logic [AW-1:0] two_x;
  logic [AW-1:0] mag;

  always_comb begin
    one_x  = {{2{mcand[W-1]}}, mcand};
    two_x  = {mcand[W-1], mcand, 1'b0};
    mag    = digit.dbl ? two_x : one_x;
    if (digit.zero) begin
      addend = '0;
      cin    = 1'b0;
    end else begin
      addend = digit.neg ? ~mag : mag;
      cin    = digit.neg;
    end
  end

endmodule

// File: rtl/booth4_seq.sv
// Iteration sequencer: accepts a start when idle, counts STEPS work cycles.
module booth4_seq
  import booth4_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step,
  output logic last
);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) state_q <= ST_IDLE;
    end
  end

endmodule

// File: rtl/booth4_mul.sv
// Radix-4 Booth sequential signed multiplier. W must be even and at least 4.
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int W = 8,
  localparam int AW = W + 2,
  localparam int STEPS = W / 2,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);

  logic load, step, last;

  booth4_seq #(.STEPS(STEPS)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .load (load),
    .step (step),
    .last (last)
  );

  // Datapath state: high accumulator, shifting multiplier, guard bit below it
  logic [W-1:0]  mcand_q;
  logic [AW-1:0] acc_q;
  logic [W-1:0]  mq_q;
  logic          guard_q;

  bdigit_t       digit;
  logic [AW-1:0] addend;
  logic          cin;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_nx;
  logic [W-1:0]  mq_nx;

  booth4_recode u_rec (
    .win  ({mq_q[1:0], guard_q}),
    .digit(digit)
  );

  booth4_addend #(.W(W)) u_add (
    .mcand (mcand_q),
    .digit (digit),
    .addend(addend),
    .cin   (cin)
  );

  always_comb begin
    sum    = acc_q + addend + AW'(cin);
    acc_nx = {{2{sum[AW-1]}}, sum[AW-1:2]};
    mq_nx  = {sum[1:0], mq_q[W-1:2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      guard_q <= 1'b0;
    end else if (load) begin
      mcand_q <= mcand;
      acc_q   <= '0;
      mq_q    <= mplier;
      guard_q <= 1'b0;
    end else if (step) begin
      acc_q   <= acc_nx;
      mq_q    <= mq_nx;
      guard_q <= mq_q[1];
    end
  end

  // Registered result and completion pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (last) product <= {acc_nx[W-1:0], mq_nx};
    end
  end

endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int W = 8,
  localparam int STEPS = W / 2,
  localparam int PW = 2 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [W-1:0]  mcand,
  input logic [W-1:0]  mplier,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] product
);

  logic signed [W-1:0] a_cap, b_cap;
  logic signed [PW-1:0] ref_prod;
  int unsigned          cyc;
  logic                 accept;

  assign accept   = start && !busy;
  assign ref_prod = a_cap * b_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      b_cap <= '0;
      cyc   <= 0;
    end else if (accept) begin
      a_cap <= mcand;
      b_cap <= mplier;
      cyc   <= 0;
    end else if (busy) begin
      cyc <= cyc + 1;
    end
  end

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == STEPS && !busy));

  // R1
  product_value_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ref_prod));

  // R5
  min_by_min_chk: assert property (@(posedge clk) disable iff (rst)
    (done && a_cap == {1'b1, {(W-1){1'b0}}} && b_cap == {1'b1, {(W-1){1'b0}}})
      |-> (product == (PW'(1) << (PW - 2))));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);

endmodule

bind booth4_mul booth4_mul_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .mcand  (mcand),
  .mplier (mplier),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/tb_booth4_mul.sv
module tb_booth4_mul;
  localparam int W = 8;
  localparam int PW = 2 * W;
  localparam int STEPS = W / 2;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  always #5 clk = ~clk;

  booth4_mul #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  typedef struct {
    logic signed [PW-1:0] exp;
    int                   issued;
    string                tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: waits for idle, raises start for one cycle, queues the expectation
  task automatic issue(input int a, input int b, input string tag);
    logic signed [W-1:0] sa, sb;
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    sa = W'(a);
    sb = W'(b);
    it.exp    = sa * sb;
    it.issued = cyc;
    it.tag    = tag;
    q.push_back(it);
    mcand  = sa;
    mplier = sb;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: compares each done against the head of the queue
  always @(negedge clk) begin
    if (!rst && done) begin
      seen++;
      if (q.size() == 0) begin
        check(1'b0, "R4", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check($signed(product) == it.exp, it.tag, "product",
              longint'($signed(product)), longint'(it.exp));
        // R3: done one rising edge for the start plus STEPS edges later
        check(cyc - it.issued == STEPS + 1, "R3", "latency",
              cyc - it.issued, STEPS + 1);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R7", "reset outputs",
          longint'({busy, done, product}), 0);
    rst = 1'b0;

    // R8 recoding examples, R5 most negative operands
    issue(23, 90, "R8");
    issue(23, 6, "R8");
    issue(LO, LO, "R5");
    issue(LO, HI, "R5");
    issue(HI, LO, "R5");
    issue(LO, 1, "R5");
    issue(-1, LO, "R5");
    issue(0, LO, "R1");
    issue(HI, HI, "R1");

    // R4: start during busy with other operands must not disturb the run
    issue(-77, 53, "R4");
    mcand  = W'(11);
    mplier = W'(-9);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    // R6: product holds its last value while idle
    held = product;
    repeat (3) @(negedge clk);
    check(product == held && $signed(product) == -77 * 53, "R6", "held product",
          longint'($signed(product)), -77 * 53);
    // R2: busy in the cycle after an accepted start
    @(negedge clk);
    mcand = W'(5);
    mplier = W'(7);
    start = 1'b1;
    q.push_back('{exp: 35, issued: cyc, tag: "R2"});
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);

    // R1 sweep: every multiplicand against a strided set of multipliers
    for (int ai = LO; ai <= HI; ai++) begin
      for (int bi = LO; bi <= HI; bi += 3) begin
        issue(ai, bi, "R1");
      end
    end

    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R1", "queue drained", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule